// File: doc/BRIEF.md
# TDM Frame Slot Demultiplexer

This block takes a serial time-division-multiplexed stream, one bit per clock, split into 16-bit slots sent most significant bit first. A single-cycle frame-sync pulse marks the first bit of slot 0. The block counts bits and slots, rebuilds each slot word, and hands the words from four fixed slots to two stereo output pairs. Pair A reads slots 2 and 3. Pair B reads slots 4 and 5.

A small control word sets the following:
- A mono flag for each pair.
- The frame length, 32 or 16 slots.
- Whether a new frame length takes effect at once or only at the next frame boundary.
- A bit-clock select request. The block holds this request back until slot 5 has been fully received.

Software writes the control word through a plain write strobe. It is cleared and write-protected while power-down is held low.

Top module: `tdm_slot_demux`

## Requirements
- R1: In stereo mode the word received in slot 2 goes to pair A left and the word in slot 3 goes to pair A right. Likewise, slot 4 goes to pair B left and slot 5 goes to pair B right. Slots are numbered from 0.
- R2: When a pair is in mono mode, its even slot updates both its left and right outputs in the same cycle. Its odd slot changes neither output.
- R3: Control bit 0 is the mono flag of pair A and control bit 1 is the mono flag of pair B. A value of 1 means mono and 0 means stereo, and each flag acts only on its own pair.
- R4: Control bit 2 sets the frame length: 0 gives 32 slots and 1 gives 16 slots. Without a new frame-sync, the slot counter returns to 0 after the last slot of the effective length.
- R5: While control bit 3 is 0, a frame-length change waits until the current frame wraps or a frame-sync arrives.
- R6: While control bit 3 is 1, the frame length written applies to the current frame. If the slot being received is already at or beyond the new length, the counter goes to 0 at the next slot boundary.
- R7: The output `bclk_sel` follows control bit 4. It takes a new value only in the cycle after the last bit of slot 5.
- R8: After reset all control bits are 0. While `pwr_n` is low they are held at 0 and writes are ignored.
- R9: Slots are 16 bits, shifted in MSB first. The frame-sync pulse coincides with bit 0 of slot 0. No output, strobe or slot advance occurs before the first frame-sync.
- R10: Each output has a valid strobe that is high for exactly one cycle: the cycle after the last bit of the slot that updated that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_n | input | 1 | Active-low power-down; clears and locks the control word |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 5 | Control word: [0] mono A, [1] mono B, [2] 16-slot frame, [3] immediate length, [4] clock select |
| fsync | input | 1 | Frame-sync pulse on bit 0 of slot 0 |
| sdata | input | 1 | Serial data, MSB first |
| a_left | output | 16 | Pair A left sample |
| a_right | output | 16 | Pair A right sample |
| b_left | output | 16 | Pair B left sample |
| b_right | output | 16 | Pair B right sample |
| a_left_vld | output | 1 | Pair A left update strobe |
| a_right_vld | output | 1 | Pair A right update strobe |
| b_left_vld | output | 1 | Pair B left update strobe |
| b_right_vld | output | 1 | Pair B right update strobe |
| bclk_sel | output | 1 | Effective bit-clock select |
| slot_num | output | 5 | Index of the slot now being received |

## Verification
Routing is exercised with frames whose slot words encode both a per-frame seed and the slot index. A misrouted or stale word therefore shows up as a wrong value, not just as a wrong strobe. The four mono combinations are each tried, and the number of right-channel strobes is counted, which separates "odd slot discarded" from "odd slot overwrote the mirrored value". Frame length is probed by letting the counter run free past slot 15: a deferred change must still reach slot 16 before it wraps, while an immediate change made at slot 8 and one made at slot 20 must both return to 0 on schedule.

// File: rtl/tdm_demux_pkg.sv
package tdm_demux_pkg;
  localparam int CFG_W = 5;

  typedef struct packed {
    logic       clk_sel;   // [4]
    logic       len_now;   // [3]
    logic       len16;     // [2]
    logic [1:0] mono;      // [1]=pair B, [0]=pair A
  } ctl_t;
endpackage

// File: rtl/tdm_ctl_reg.sv
module tdm_ctl_reg
  import tdm_demux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output ctl_t             ctl_q
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (!pwr_n)  ctl_d = '0;
    else if (we) ctl_d = ctl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // R8
  pwrdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (ctl_q == '0));
endmodule

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int W          = 16,
  parameter int SB         = 5,
  parameter int LAST_OWNED = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          sdata,
  input  logic          len16,
  input  logic          len_now,
  input  logic          clk_sel_req,
  output logic          word_done,
  output logic [W-1:0]  word,
  output logic [SB-1:0] cur_slot,
  output logic [SB-1:0] slot_q,
  output logic          bclk_sel
);
  localparam int BB = $clog2(W);
  localparam logic [BB-1:0] LAST_BIT = BB'(W - 1);
  localparam logic [SB:0]   FULL_LEN = (SB+1)'(2**SB);
  localparam logic [SB:0]   HALF_LEN = (SB+1)'(2**(SB-1));
  localparam logic [SB-1:0] OWN_END  = SB'(LAST_OWNED);

  logic [BB-1:0] bit_q, bit_d, cur_bit;
  logic [SB-1:0] slot_d;
  logic [W-1:0]  sh_q, sh_d;
  logic          lock_q, lock_d, act;
  logic          eff16_q, eff16_d, use16, wrap, boundary;
  logic          bsel_d;
  logic [SB:0]   len, nxt;

  always_comb begin
    act       = lock_q | fsync;
    cur_bit   = fsync ? '0 : bit_q;
    cur_slot  = fsync ? '0 : slot_q;
    sh_d      = {sh_q[W-2:0], sdata};
    word      = sh_d;
    word_done = act && (cur_bit == LAST_BIT);
    use16     = len_now ? len16 : eff16_q;
    len       = use16 ? HALF_LEN : FULL_LEN;
    nxt       = {1'b0, cur_slot} + 1'b1;
    wrap      = (nxt >= len);
    boundary  = fsync || (word_done && wrap);
    lock_d    = act;
    eff16_d   = boundary ? len16 : eff16_q;
    bit_d     = bit_q;
    slot_d    = slot_q;
    if (act) begin
      if (word_done) begin
        bit_d  = '0;
        slot_d = wrap ? '0 : nxt[SB-1:0];
      end else begin
        bit_d  = cur_bit + 1'b1;
        slot_d = cur_slot;
      end
    end
    bsel_d = (word_done && cur_slot == OWN_END) ? clk_sel_req : bclk_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= '0;
      slot_q   <= '0;
      sh_q     <= '0;
      lock_q   <= 1'b0;
      eff16_q  <= 1'b0;
      bclk_sel <= 1'b0;
    end else begin
      bit_q    <= bit_d;
      slot_q   <= slot_d;
      sh_q     <= sh_d;
      lock_q   <= lock_d;
      eff16_q  <= eff16_d;
      bclk_sel <= bsel_d;
    end
  end

  // R7
  bclk_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_sel != $past(bclk_sel)) |-> $past(word_done && cur_slot == OWN_END));

  // R9
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != $past(slot_q)) |-> $past(word_done || fsync));
endmodule

// File: rtl/tdm_route.sv
module tdm_route #(
  parameter int W     = 16,
  parameter int SB    = 5,
  parameter int PAIRS = 2,
  parameter int BASE  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    word_done,
  input  logic [W-1:0]            word,
  input  logic [SB-1:0]           slot,
  input  logic [PAIRS-1:0]        mono,
  output logic [PAIRS-1:0][W-1:0] out_l,
  output logic [PAIRS-1:0][W-1:0] out_r,
  output logic [PAIRS-1:0]        vld_l,
  output logic [PAIRS-1:0]        vld_r
);
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam logic [SB-1:0] EVEN = SB'(BASE + 2*p);
    localparam logic [SB-1:0] ODD  = SB'(BASE + 2*p + 1);

    logic         hit_e, hit_o, upd_r;
    logic [W-1:0] l_d, r_d;

    always_comb begin
      hit_e = word_done && (slot == EVEN);
      hit_o = word_done && (slot == ODD) && !mono[p];
      upd_r = hit_o || (hit_e && mono[p]);
      l_d   = hit_e ? word : out_l[p];
      r_d   = upd_r ? word : out_r[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_l[p] <= '0;
        out_r[p] <= '0;
        vld_l[p] <= 1'b0;
        vld_r[p] <= 1'b0;
      end else begin
        out_l[p] <= l_d;
        out_r[p] <= r_d;
        vld_l[p] <= hit_e;
        vld_r[p] <= upd_r;
      end
    end

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_l[p] || vld_r[p]) |=> !(vld_l[p] || vld_r[p]));

    // R2
    mono_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mono[p]) && vld_r[p]) |-> (vld_l[p] && out_r[p] == out_l[p]));
  end
endmodule

// File: rtl/tdm_slot_demux.sv
module tdm_slot_demux
  import tdm_demux_pkg::*;
#(
  parameter int W          = 16,
  parameter int SB         = 5,
  parameter int PAIRS      = 2,
  parameter int BASE       = 2,
  parameter int LAST_OWNED = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             fsync,
  input  logic             sdata,
  output logic [W-1:0]     a_left,
  output logic [W-1:0]     a_right,
  output logic [W-1:0]     b_left,
  output logic [W-1:0]     b_right,
  output logic             a_left_vld,
  output logic             a_right_vld,
  output logic             b_left_vld,
  output logic             b_right_vld,
  output logic             bclk_sel,
  output logic [SB-1:0]    slot_num
);
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  ctl_t                    ctl;
  logic                    word_done;
  logic [W-1:0]            word;
  logic [SB-1:0]           cur_slot;
  logic [PAIRS-1:0][W-1:0] out_l, out_r;
  logic [PAIRS-1:0]        vld_l, vld_r;

  tdm_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_i), .pwr_n(pwr_n),
    .we(cfg_we), .wdata(cfg_wdata), .ctl_q(ctl)
  );

  tdm_slot_ctr #(.W(W), .SB(SB), .LAST_OWNED(LAST_OWNED)) u_ctr (
    .clk(clk), .rst_n(rst_i), .fsync(fsync), .sdata(sdata),
    .len16(ctl.len16), .len_now(ctl.len_now), .clk_sel_req(ctl.clk_sel),
    .word_done(word_done), .word(word), .cur_slot(cur_slot),
    .slot_q(slot_num), .bclk_sel(bclk_sel)
  );

  tdm_route #(.W(W), .SB(SB), .PAIRS(PAIRS), .BASE(BASE)) u_route (
    .clk(clk), .rst_n(rst_i), .word_done(word_done), .word(word),
    .slot(cur_slot), .mono(ctl.mono[PAIRS-1:0]),
    .out_l(out_l), .out_r(out_r), .vld_l(vld_l), .vld_r(vld_r)
  );

  assign a_left      = out_l[0];
  assign a_right     = out_r[0];
  assign b_left      = out_l[1];
  assign b_right     = out_r[1];
  assign a_left_vld  = vld_l[0];
  assign a_right_vld = vld_r[0];
  assign b_left_vld  = vld_l[1];
  assign b_right_vld = vld_r[1];
endmodule

// File: tb/tdm_slot_demux_bench.sv
`timescale 1ns/1ps
module tdm_slot_demux_bench;
  logic clk = 1'b0, rst_n = 1'b0, pwr_n = 1'b1;
  logic cfg_we = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic [15:0] a_left, a_right, b_left, b_right;
  logic a_left_vld, a_right_vld, b_left_vld, b_right_vld, bclk_sel;
  logic [4:0] slot_num;

  int total = 0, bad = 0;
  int n_al = 0, n_ar = 0, n_bl = 0, n_br = 0;

  always #2.5 clk = ~clk;

  tdm_slot_demux u_tdm_slot_demux (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .fsync(fsync), .sdata(sdata),
    .a_left(a_left), .a_right(a_right), .b_left(b_left), .b_right(b_right),
    .a_left_vld(a_left_vld), .a_right_vld(a_right_vld),
    .b_left_vld(b_left_vld), .b_right_vld(b_right_vld),
    .bclk_sel(bclk_sel), .slot_num(slot_num)
  );

  always @(posedge clk) begin
    #1;
    if (a_left_vld)  n_al++;
    if (a_right_vld) n_ar++;
    if (b_left_vld)  n_bl++;
    if (b_right_vld) n_br++;
  end

  // cfg[12:8], frame seed [7:0]
  localparam logic [12:0] VEC [6] = '{
    {5'h00, 8'h11}, {5'h01, 8'h22}, {5'h02, 8'h33},
    {5'h03, 8'h44}, {5'h00, 8'h5A}, {5'h02, 8'hC3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wf(input logic [7:0] seed, input int s);
    return {seed, 3'b000, 5'(s)};
  endfunction

  task automatic send_slot(input logic [15:0] w, input bit fs, input bit we, input logic [4:0] wd);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      fsync     = fs && (i == 0);
      sdata     = w[15-i];
      cfg_we    = we && (i == 0);
      cfg_wdata = wd;
    end
  endtask

  task automatic wr(input logic [4:0] wd);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = wd;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic run_frame(input logic [7:0] seed, output int dal, output int dar,
                           output int dbl, output int dbr);
    int s0, s1, s2, s3;
    s0 = n_al; s1 = n_ar; s2 = n_bl; s3 = n_br;
    for (int s = 0; s < 6; s++) send_slot(wf(seed, s), s == 0, 1'b0, '0);
    settle();
    dal = n_al - s0; dar = n_ar - s1; dbl = n_bl - s2; dbr = n_br - s3;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dal, dar, dbl, dbr;
    logic [7:0] seed;
    logic [4:0] cf;
    logic [15:0] er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    settle();
    // R8 reset state
    chk(a_left == 0 && a_right == 0, "R8 pair A reset", a_left, 0);
    chk(b_left == 0 && b_right == 0, "R8 pair B reset", b_left, 0);
    chk(bclk_sel == 0, "R8 bclk_sel reset", bclk_sel, 0);
    chk(slot_num == 0, "R9 slot reset", slot_num, 0);

    // R9 nothing happens before the first frame-sync
    for (int i = 0; i < 40; i++) begin @(negedge clk); sdata = i[0]; end
    settle();
    chk(slot_num == 0, "R9 no advance before sync", slot_num, 0);
    chk(n_al + n_ar + n_bl + n_br == 0, "R9 no strobe before sync", n_al + n_ar + n_bl + n_br, 0);

    // R1 R2 R3 R10 vector table
    foreach (VEC[k]) begin
      cf = VEC[k][12:8]; seed = VEC[k][7:0];
      wr(cf);
      run_frame(seed, dal, dar, dbl, dbr);
      chk(a_left == wf(seed, 2), "R1 pair A left", a_left, wf(seed, 2));
      er = cf[0] ? wf(seed, 2) : wf(seed, 3);
      chk(a_right == er, "R2 R3 pair A right", a_right, er);
      chk(b_left == wf(seed, 4), "R1 pair B left", b_left, wf(seed, 4));
      er = cf[1] ? wf(seed, 4) : wf(seed, 5);
      chk(b_right == er, "R2 R3 pair B right", b_right, er);
      chk(dal == 1 && dbl == 1, "R10 left strobe count", dal * 16 + dbl, 17);
      chk(dar == 1 && dbr == 1, "R10 R2 right strobe count", dar * 16 + dbr, 17);
    end

    // R8 power-down clears and blocks writes
    wr(5'h03);
    @(negedge clk); pwr_n = 1'b0;
    wr(5'h03);
    @(negedge clk); pwr_n = 1'b1;
    run_frame(8'h77, dal, dar, dbl, dbr);
    chk(a_right == wf(8'h77, 3), "R8 pair A stereo after power-down", a_right, wf(8'h77, 3));
    chk(b_right == wf(8'h77, 5), "R8 pair B stereo after power-down", b_right, wf(8'h77, 5));

    // R7 clock select deferred to end of slot 5
    send_slot(wf(8'h01, 0), 1'b1, 1'b0, '0);
    send_slot(wf(8'h01, 1), 1'b0, 1'b0, '0);
    send_slot(wf(8'h01, 2), 1'b0, 1'b1, 5'h10);
    send_slot(wf(8'h01, 3), 1'b0, 1'b0, '0);
    send_slot(wf(8'h01, 4), 1'b0, 1'b0, '0);
    settle();
    chk(bclk_sel == 0, "R7 held before slot 5 ends", bclk_sel, 0);
    send_slot(wf(8'h01, 5), 1'b0, 1'b0, '0);
    settle();
    chk(bclk_sel == 1, "R7 applied after slot 5", bclk_sel, 1);

    // R5 deferred length change
    wr(5'h00);
    for (int s = 0; s < 16; s++) send_slot(16'h0, s == 0, s == 10, 5'h04);
    settle();
    chk(slot_num == 16, "R5 R4 current frame keeps 32", slot_num, 16);
    for (int s = 16; s < 32; s++) send_slot(16'h0, 1'b0, 1'b0, '0);
    settle();
    chk(slot_num == 0, "R4 wrap after 32 slots", slot_num, 0);
    for (int s = 0; s < 16; s++) send_slot(16'h0, 1'b0, 1'b0, '0);
    settle();
    chk(slot_num == 0, "R4 R5 wrap after 16 slots", slot_num, 0);

    // R6 immediate change while past the new length
    wr(5'h00);
    for (int s = 0; s < 21; s++) send_slot(16'h0, s == 0, s == 20, 5'h0C);
    settle();
    chk(slot_num == 0, "R6 wrap from slot 20", slot_num, 0);

    // R6 immediate change before the new length
    wr(5'h08);
    for (int s = 0; s < 16; s++) send_slot(16'h0, s == 0, s == 8, 5'h0C);
    settle();
    chk(slot_num == 0, "R6 wrap after slot 15", slot_num, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule